// File: doc/BRIEF.md
# Quad-LUT Logic Analyzer Trigger

This block decides, sample by sample, whether a 16-channel logic analyzer capture should trigger. The channels are cut into four groups of four. The four bits of a group address a 16-entry truth table, and each table returns one match bit. The block holds three sets of four tables. Set 0 gives a value/mask match. Sets 1 and 2 each pick out one edge channel. A 16-entry glue table then combines the current and previous results of the two edge sets, and its output is ANDed with the value/mask match.

The host fills the tables row by row while the trigger is not armed. A row write carries a row index and one bit for every (set, group) table. The glue table is loaded with a separate write. The host then arms the block and streams samples in with a valid strobe. The first qualifying sample produces a one-cycle registered trigger pulse and sets a sticky triggered flag. The flag stays set until the block is armed again or disarmed.

The controller has three states. ST_IDLE waits for the host. ST_ARMED evaluates samples. ST_FIRED holds the triggered flag. The transitions are:
- arm_req: ST_IDLE to ST_ARMED, and also ST_FIRED to ST_ARMED.
- rearm: ST_ARMED to ST_ARMED. This clears the history.
- hit: ST_ARMED to ST_FIRED.
- stop: any state to ST_IDLE. A disarm takes priority over an arm.

Top module: `quad_lut_trigger`

## Requirements
- R1: After reset, trig_pulse, triggered and armed are all 0, and the glue table holds all ones.
- R2: A row write with row_idx = r stores row_bits[s*4+q] as entry bit r of the table for set s, group q. Rows are written one at a time, 16 rows per full load.
- R3: Group q is indexed by smp_data[4q+3:4q]. The value/mask match is the AND of the four set-0 table bits selected this way.
- R4: The glue table is indexed by 4 bits. Bit 2k is the previous match of edge set k+1, and bit 2k+1 is its current match. The trigger condition is the value/mask match AND the selected glue bit.
- R5: With glue 0x4444 and edge set 1 selecting one channel, a 0-to-1 change on that channel triggers.
- R6: With glue 0x2222, a 1-to-0 change on the edge-set-1 channel triggers. A 0-to-1 change does not.
- R7: With glue 0x4F44, a rise on either edge channel triggers, so the two edge terms are ORed.
- R8: The edge history resets to 0 and is cleared on arming. The first sample after arming is compared against itself, so no edge fires on that sample.
- R9: trig_pulse is high for exactly one cycle, in the cycle after the first qualifying sample. triggered then stays 1, and later matches give no pulse until the block is rearmed.
- R10: Row and glue writes are ignored while the block is armed.
- R11: Samples count only when smp_valid is 1. Cycles without a valid sample neither trigger nor advance the edge history.
- R12: disarm returns the block to idle. The block never pulses while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | smp_data holds a new sample |
| smp_data | input | 16 | Channel sample |
| arm | input | 1 | Arm or rearm the trigger, clearing history and flag |
| disarm | input | 1 | Return to idle (wins over arm) |
| row_we | input | 1 | Table row write strobe |
| row_idx | input | 4 | Row written |
| row_bits | input | 12 | Bit s*4+q goes to set s, group q |
| glue_we | input | 1 | Glue table write strobe |
| glue_data | input | 16 | Glue table contents |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| triggered | output | 1 | Sticky triggered flag |
| armed | output | 1 | Block is evaluating samples |

## Verification
The assertions check the controller's pulse discipline on every cycle:
- The pulse lasts a single cycle and always comes with the flag.
- The flag holds until an arm or a disarm.
- A pulse always follows a valid sample taken while armed.
- A disarm leaves the block idle.

The content-dependent behaviour can only be shown by the bench's scenarios, each with tables it has computed itself:
- the value/mask truth tables and group indexing;
- rise, fall and ORed edges through the glue table;
- the empty history on the first sample;
- writes ignored while armed;
- history that survives invalid cycles.

// File: rtl/qlt_pkg.sv
package qlt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRED = 2'd2
    } qlt_state_e;
endpackage

// File: rtl/qlt_lut_bank.sv
// Truth-table storage: NUM_SETS sets of one table per channel group.
// Written a row at a time; read combinationally by the current sample.
module qlt_lut_bank #(
    parameter int NUM_CH   = 16,
    parameter int QUAD_W   = 4,
    parameter int NUM_SETS = 3
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  row_we,
    input  logic [QUAD_W-1:0]                     row_idx,
    input  logic [NUM_SETS*(NUM_CH/QUAD_W)-1:0]   row_bits,
    input  logic [NUM_CH-1:0]                     sample,
    output logic [NUM_SETS-1:0]                   set_match
);
    localparam int NUM_QUADS = NUM_CH / QUAD_W;
    localparam int DEPTH     = 1 << QUAD_W;

    logic [NUM_SETS*NUM_QUADS-1:0] quad_hit;

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        for (genvar q = 0; q < NUM_QUADS; q++) begin : g_quad
            logic [DEPTH-1:0] entry;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    entry <= '0;
                end else if (row_we) begin
                    entry[row_idx] <= row_bits[s*NUM_QUADS+q];
                end
            end

            assign quad_hit[s*NUM_QUADS+q] = entry[sample[q*QUAD_W +: QUAD_W]];
        end
        assign set_match[s] = &quad_hit[s*NUM_QUADS +: NUM_QUADS];
    end
endmodule

// File: rtl/qlt_edge_hist.sv
// Previous-sample match history for the edge sets and the glue index.
module qlt_edge_hist #(
    parameter int NUM_EDGE = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    advance,
    input  logic [NUM_EDGE-1:0]     cur,
    output logic [2*NUM_EDGE-1:0]   glue_idx
);
    logic [NUM_EDGE-1:0] prev_q;
    logic                primed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else if (clear) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else if (advance) begin
            prev_q   <= cur;
            primed_q <= 1'b1;
        end
    end

    // Before any history exists the sample is compared with itself.
    for (genvar k = 0; k < NUM_EDGE; k++) begin : g_idx
        assign glue_idx[2*k]   = primed_q ? prev_q[k] : cur[k];
        assign glue_idx[2*k+1] = cur[k];
    end
endmodule

// File: rtl/qlt_ctrl.sv
// Arm / fire / idle controller with registered trigger pulse.
module qlt_ctrl
    import qlt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic disarm,
    input  logic smp_valid,
    input  logic cond,
    output logic eval,
    output logic restart,
    output logic cfg_open,
    output logic trig_pulse,
    output logic triggered,
    output logic armed
);
    qlt_state_e state_q, state_d;
    logic       hit;

    assign eval    = (state_q == ST_ARMED) && smp_valid && !arm && !disarm;
    assign hit     = eval && cond;
    assign restart = arm && !disarm;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (restart) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (disarm)   state_d = ST_IDLE;
                else if (hit) state_d = ST_FIRED;
            end
            ST_FIRED: begin
                if (disarm)       state_d = ST_IDLE;
                else if (restart) state_d = ST_ARMED;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_pulse <= 1'b0;
        else        trig_pulse <= hit;
    end

    assign triggered = (state_q == ST_FIRED);
    assign armed     = (state_q == ST_ARMED);
    assign cfg_open  = (state_q != ST_ARMED);
endmodule

// File: rtl/quad_lut_trigger.sv
module quad_lut_trigger #(
    parameter int NUM_CH   = 16,
    parameter int QUAD_W   = 4,
    parameter int NUM_EDGE = 2
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      smp_valid,
    input  logic [NUM_CH-1:0]                         smp_data,
    input  logic                                      arm,
    input  logic                                      disarm,
    input  logic                                      row_we,
    input  logic [QUAD_W-1:0]                         row_idx,
    input  logic [(1+NUM_EDGE)*(NUM_CH/QUAD_W)-1:0]   row_bits,
    input  logic                                      glue_we,
    input  logic [(1<<(2*NUM_EDGE))-1:0]              glue_data,
    output logic                                      trig_pulse,
    output logic                                      triggered,
    output logic                                      armed
);
    localparam int NUM_SETS = 1 + NUM_EDGE;
    localparam int GLUE_W   = 1 << (2*NUM_EDGE);

    logic [NUM_SETS-1:0]   set_match;
    logic [2*NUM_EDGE-1:0] glue_idx;
    logic [GLUE_W-1:0]     glue_q;
    logic                  eval, restart, cfg_open, cond;

    qlt_lut_bank #(.NUM_CH(NUM_CH), .QUAD_W(QUAD_W), .NUM_SETS(NUM_SETS)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .row_we(row_we && cfg_open), .row_idx(row_idx), .row_bits(row_bits),
        .sample(smp_data), .set_match(set_match)
    );

    qlt_edge_hist #(.NUM_EDGE(NUM_EDGE)) u_hist (
        .clk(clk), .rst_n(rst_n),
        .clear(restart), .advance(eval),
        .cur(set_match[NUM_SETS-1:1]), .glue_idx(glue_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   glue_q <= '1;
        else if (glue_we && cfg_open) glue_q <= glue_data;
    end

    assign cond = set_match[0] && glue_q[glue_idx];

    qlt_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .arm(arm), .disarm(disarm), .smp_valid(smp_valid), .cond(cond),
        .eval(eval), .restart(restart), .cfg_open(cfg_open),
        .trig_pulse(trig_pulse), .triggered(triggered), .armed(armed)
    );
endmodule

// File: rtl/quad_lut_trigger_chk.sv
module quad_lut_trigger_chk (
    input logic clk,
    input logic rst_n,
    input logic smp_valid,
    input logic arm,
    input logic disarm,
    input logic trig_pulse,
    input logic triggered,
    input logic armed
);
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse); // R9
    AST_PULSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> triggered); // R9
    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (triggered && !arm && !disarm) |=> triggered); // R9
    AST_PULSE_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> ($past(smp_valid) && $past(armed))); // R11
    AST_DISARM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        disarm |=> (!armed && !triggered && !trig_pulse)); // R12
    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !disarm) |=> (armed && !triggered && !trig_pulse)); // R8
endmodule

bind quad_lut_trigger quad_lut_trigger_chk chk_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .arm(arm),
    .disarm(disarm), .trig_pulse(trig_pulse), .triggered(triggered),
    .armed(armed)
);

// File: tb/quad_lut_trigger_tb_top.sv
`timescale 1ns/1ps
module quad_lut_trigger_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        arm = 1'b0;
    logic        disarm = 1'b0;
    logic        row_we = 1'b0;
    logic [3:0]  row_idx = '0;
    logic [11:0] row_bits = '0;
    logic        glue_we = 1'b0;
    logic [15:0] glue_data = '0;
    logic        trig_pulse, triggered, armed;

    int n_checks = 0;
    int n_errors = 0;
    logic [15:0] tb_tab [3][4];

    always #2 clk = ~clk;

    quad_lut_trigger dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .arm(arm), .disarm(disarm), .row_we(row_we), .row_idx(row_idx),
        .row_bits(row_bits), .glue_we(glue_we), .glue_data(glue_data),
        .trig_pulse(trig_pulse), .triggered(triggered), .armed(armed)
    );

    task automatic check(input string tag, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] vm_entry(input logic [15:0] value,
                                             input logic [15:0] mask, input int q);
        logic [15:0] e;
        for (int j = 0; j < 16; j++) begin
            logic ok;
            ok = 1'b1;
            for (int k = 0; k < 4; k++) begin
                if (mask[q*4+k] && (value[q*4+k] != j[k])) ok = 1'b0;
            end
            e[j] = ok;
        end
        return e;
    endfunction

    task automatic set_vm(input int s, input logic [15:0] value, input logic [15:0] mask);
        for (int q = 0; q < 4; q++) tb_tab[s][q] = vm_entry(value, mask, q);
    endtask

    // R2: row r carries bit r of every (set, group) table at s*4+q
    task automatic program_all(input logic [15:0] glue);
        for (int r = 0; r < 16; r++) begin
            row_idx = r[3:0];
            for (int s = 0; s < 3; s++)
                for (int q = 0; q < 4; q++) row_bits[s*4+q] = tb_tab[s][q][r];
            row_we = 1'b1;
            @(negedge clk);
        end
        row_we = 1'b0;
        glue_data = glue;
        glue_we = 1'b1;
        @(negedge clk);
        glue_we = 1'b0;
    endtask

    task automatic do_arm();
        arm = 1'b1; @(negedge clk); arm = 1'b0;
    endtask

    task automatic feed(input logic [15:0] s);
        smp_data = s; smp_valid = 1'b1; @(negedge clk); smp_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 trig_pulse", trig_pulse, 1'b0);
        check("R1 triggered", triggered, 1'b0);
        check("R1 armed", armed, 1'b0);
    endtask

    task automatic t_value_mask();
        set_vm(0, 16'h1234, 16'hF0F0);
        set_vm(1, 16'h0000, 16'h0000);
        set_vm(2, 16'h0000, 16'h0000);
        program_all(16'hFFFF);
        do_arm();
        check("R12 armed after arm", armed, 1'b1);
        feed(16'h0000);
        check("R3 mismatch group1", trig_pulse, 1'b0);
        feed(16'h1F2F);
        check("R3 mismatch group1 value 2", trig_pulse, 1'b0);
        feed(16'h1F3F);
        check("R2 R3 match pulse", trig_pulse, 1'b1);
        check("R9 flag set", triggered, 1'b1);
        feed(16'h1F3F);
        check("R9 single pulse", trig_pulse, 1'b0);
        check("R9 flag held", triggered, 1'b1);
    endtask

    task automatic t_rise();
        set_vm(0, 16'h0000, 16'h0000);
        set_vm(1, 16'h0020, 16'h0020);
        program_all(16'h4444);
        do_arm();
        check("R9 rearm clears flag", triggered, 1'b0);
        feed(16'h0020);
        check("R8 no edge on first sample", trig_pulse, 1'b0);
        feed(16'h0000);
        check("R5 fall ignored", trig_pulse, 1'b0);
        feed(16'h0020);
        check("R4 R5 rise pulse", trig_pulse, 1'b1);
    endtask

    task automatic t_fall();
        program_all(16'h2222);
        do_arm();
        feed(16'h0000);
        check("R8 first sample quiet", trig_pulse, 1'b0);
        feed(16'h0020);
        check("R6 rise ignored", trig_pulse, 1'b0);
        feed(16'h0000);
        check("R6 fall pulse", trig_pulse, 1'b1);
    endtask

    task automatic t_or();
        set_vm(1, 16'h0004, 16'h0004);
        set_vm(2, 16'h0200, 16'h0200);
        program_all(16'h4F44);
        do_arm();
        feed(16'h0000);
        feed(16'h0200);
        check("R7 rise on edge set 2", trig_pulse, 1'b1);
        do_arm();
        feed(16'h0200);
        check("R8 first sample after rearm", trig_pulse, 1'b0);
        feed(16'h0204);
        check("R7 rise on edge set 1", trig_pulse, 1'b1);
    endtask

    task automatic t_valid_gap();
        set_vm(1, 16'h0020, 16'h0020);
        set_vm(2, 16'h0000, 16'h0000);
        program_all(16'h4444);
        do_arm();
        feed(16'h0000);
        smp_data = 16'h0020;
        repeat (3) @(negedge clk);
        check("R11 invalid cycles do not trigger", trig_pulse, 1'b0);
        check("R11 still armed", armed, 1'b1);
        feed(16'h0020);
        check("R11 history kept across gap", trig_pulse, 1'b1);
    endtask

    task automatic t_locked();
        set_vm(0, 16'h0001, 16'h0001);
        set_vm(1, 16'h0000, 16'h0000);
        program_all(16'hFFFF);
        do_arm();
        for (int r = 0; r < 16; r++) begin
            row_idx = r[3:0]; row_bits = '1; row_we = 1'b1;
            @(negedge clk);
        end
        row_we = 1'b0;
        glue_data = 16'h0000; glue_we = 1'b1; @(negedge clk); glue_we = 1'b0;
        feed(16'h0000);
        check("R10 row writes ignored while armed", trig_pulse, 1'b0);
        feed(16'h0001);
        check("R10 glue write ignored while armed", trig_pulse, 1'b1);
        disarm = 1'b1; @(negedge clk); disarm = 1'b0;
        check("R12 idle after disarm", armed, 1'b0);
        check("R12 flag cleared", triggered, 1'b0);
        feed(16'h0001);
        check("R12 no pulse while idle", trig_pulse, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_value_mask();
        t_rise();
        t_fall();
        t_or();
        t_valid_gap();
        t_locked();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #800000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule